// File: doc/BRIEF.md
# I/O Soft-Switch and Slot Decoder

This block sits on the processor's bus and answers every access that falls into the 256-byte I/O page at C000–C0FF and into the peripheral-card window at C080–C7FF. Most switches in the page are set or cleared by the address alone. An even/odd address pair writes address bit 0 into one flag, whatever the access direction, and the data bus is ignored. A few switches respond only to writes. A group of status addresses reports one flag each in bit 7. The block also holds a keyboard strobe, a test-mode flag, a speaker level that flips on every touch, and an 8-bit card-mask register.

For the card window the block computes a slot number from whichever of the two sub-windows was hit. It then uses the card mask, after forcing slots 0 and 3 off, to choose between the external card for that slot and the internal ROM. State changes take effect at the clock edge that ends the access. Read data and the select lines are combinational from the current address and state.

Top module: `io_softswitch_decoder`

## Requirements
- R1: After reset, every display switch, the keyboard strobe, test mode, the speaker level and the card mask are 0.
- R2: Any access, read or write, to C050/C051, C052/C053, C054/C055 or C056/C057 loads address bit 0 into text (disp_sw[0]), mixed (disp_sw[1]), page 2 (disp_sw[2]) or hi-res (disp_sw[3]) respectively.
- R3: Any access to C05E/C05F loads the inverse of address bit 0 into annunciator 3 (disp_sw[4]).
- R4: Only writes to C000/C001, C00C/C00D and C00E/C00F load address bit 0 into 80-store (disp_sw[5]), 80-column (disp_sw[6]) and alternate charset (disp_sw[7]). Reads of those addresses leave the switches unchanged.
- R5: Reads return one flag in bit 7 with bits 6:0 zero: C018 80-store, C019 always 0, C01A text, C01B mixed, C01C page 2, C01D hi-res, C01E alternate charset, C01F 80-column, C046 annunciator 3.
- R6: A key_new pulse sets the keyboard strobe. A read of C000 returns the strobe in bit 7 and zeros below. When key_new and a strobe clear arrive in the same cycle, the strobe ends up set.
- R7: A read of C010 returns key_down in bit 7 and clears the strobe. A write to C010 also clears it.
- R8: Any access to C06E/C06F loads address bit 0 into test mode. A read of C06D returns test mode in bit 7.
- R9: Every access to C030, read or write, inverts the speaker level.
- R10: A write to C02D stores all 8 data bits in the card mask, and a read of C02D returns them unmodified.
- R11: For C100–C7FF the slot number is address bits 10:8. For C080–C0FF it is address bits 6:4, which is (offset − 0x80) >> 4. Outside the window the slot output is 0.
- R12: Inside the window, when bit <slot> of (card mask AND 0xF6) is 1, card_sel is asserted and a read returns 0xFF. Otherwise irom_sel is asserted. Outside the window neither select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| key_down | input | 1 | Some key is currently held |
| key_new | input | 1 | One-cycle pulse on a fresh keypress |
| rd_data | output | 8 | Read data for the current access |
| disp_sw | output | 8 | Display switches: text, mixed, page 2, hi-res, ann3, 80-store, 80-column, alt charset (bit 0 up) |
| test_mode | output | 1 | Test-mode flag |
| spkr_out | output | 1 | Speaker level |
| slot_num | output | 3 | Decoded slot number during a window access |
| card_sel | output | 1 | Route access to the external card |
| irom_sel | output | 1 | Route access to internal ROM |

## Verification
The hardest case to reach is the same-cycle collision between a fresh keypress and a strobe clear. The new-key pulse has to be raised in exactly the cycle that a C010 read or write is on the bus. The bench does this with a dedicated stimulus step that drives both in one cycle and then reads C000. The slot routing is harder than it looks, because slots 0 and 3 stay internal even with every mask bit set. The bench loads masks of all ones, all zeros and a single bit, and probes both sub-windows under each one.

// File: rtl/ioss_pkg.sv
package ioss_pkg;

  localparam int ADDR_W = 16;
  localparam int SW_W   = 8;

  // display switch bit positions
  localparam int IDX_TEXT    = 0;
  localparam int IDX_MIXED   = 1;
  localparam int IDX_PAGE2   = 2;
  localparam int IDX_HIRES   = 3;
  localparam int IDX_ANN3    = 4;
  localparam int IDX_STORE80 = 5;
  localparam int IDX_COL80   = 6;
  localparam int IDX_ALTCH   = 7;

  localparam int N_PAIR = 4;  // any-access pairs starting at C050
  localparam int N_WO   = 3;  // write-only pairs

  // offsets inside the I/O page, shifted right by one (pair index)
  localparam logic [6:0] PAIR_BASE = 7'h28;  // 0x50 >> 1
  localparam logic [6:0] ANN_PAIR  = 7'h2F;  // 0x5E >> 1
  localparam logic [6:0] TEST_PAIR = 7'h37;  // 0x6E >> 1

  localparam logic [7:0] OFF_KBD   = 8'h00;
  localparam logic [7:0] OFF_KCLR  = 8'h10;
  localparam logic [7:0] OFF_MASK  = 8'h2D;
  localparam logic [7:0] OFF_SPK   = 8'h30;
  localparam logic [7:0] OFF_ANNST = 8'h46;
  localparam logic [7:0] OFF_TSTRD = 8'h6D;
  localparam logic [4:0] STAT_GRP  = 5'h03;  // 0x18 >> 3

  typedef struct packed {
    logic [N_PAIR-1:0] pair_hit;
    logic              ann_hit;
    logic [N_WO-1:0]   wo_hit;
    logic              stat_rd;
    logic [2:0]        stat_sel;
    logic              ann_rd;
    logic              kbd_rd;
    logic              kclr_hit;
    logic              kdown_rd;
    logic              spk_hit;
    logic              test_hit;
    logic              test_rd;
    logic              mask_rd;
    logic              mask_wr;
    logic              win_hit;
    logic              hi_win;
  } dec_t;

  typedef struct packed {
    logic [SW_W-1:0] sw;
    logic            kstrobe;
    logic            test;
    logic            spkr;
    logic [7:0]      mask;
  } state_t;

endpackage

// File: rtl/ioss_decode.sv
module ioss_decode
  import ioss_pkg::*;
(
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam logic [6:0] WO_PAIR [N_WO] = '{7'h00, 7'h06, 7'h07};

  logic       io_page;
  logic       rd_acc;
  logic [7:0] off;

  assign io_page = req && (addr[15:8] == 8'hC0);
  assign rd_acc  = io_page && !wr;
  assign off     = addr[7:0];

  genvar g;
  generate
    for (g = 0; g < N_PAIR; g++) begin : g_pair
      assign dec.pair_hit[g] = io_page && (off[7:1] == PAIR_BASE + 7'(g));
    end
    for (g = 0; g < N_WO; g++) begin : g_wo
      assign dec.wo_hit[g] = io_page && wr && (off[7:1] == WO_PAIR[g]);
    end
  endgenerate

  assign dec.ann_hit  = io_page && (off[7:1] == ANN_PAIR);
  assign dec.stat_rd  = rd_acc && (off[7:3] == STAT_GRP);
  assign dec.stat_sel = off[2:0];
  assign dec.ann_rd   = rd_acc && (off == OFF_ANNST);
  assign dec.kbd_rd   = rd_acc && (off == OFF_KBD);
  assign dec.kclr_hit = io_page && (off == OFF_KCLR);
  assign dec.kdown_rd = rd_acc && (off == OFF_KCLR);
  assign dec.spk_hit  = io_page && (off == OFF_SPK);
  assign dec.test_hit = io_page && (off[7:1] == TEST_PAIR);
  assign dec.test_rd  = rd_acc && (off == OFF_TSTRD);
  assign dec.mask_rd  = rd_acc && (off == OFF_MASK);
  assign dec.mask_wr  = io_page && wr && (off == OFF_MASK);

  // card window: C080-C0FF and C100-C7FF
  assign dec.hi_win  = req && (addr[15:11] == 5'b11000) && (addr[10:8] != 3'd0);
  assign dec.win_hit = (io_page && off[7]) || dec.hi_win;

endmodule

// File: rtl/ioss_switch_bank.sv
module ioss_switch_bank
  import ioss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dec_t       dec,
  input  logic       addr_lsb,
  input  logic [7:0] wdata,
  input  logic       key_new,
  output state_t     st
);

  logic [SW_W-1:0] sw_q, sw_d;
  logic            kstb_q, kstb_d;
  logic            test_q, test_d;
  logic            spk_q, spk_d;
  logic [7:0]      mask_q, mask_d;

  logic sw_en, kstb_en, test_en, spk_en, mask_en;

  // next-state logic
  always_comb begin
    sw_d = sw_q;
    for (int i = 0; i < N_PAIR; i++) begin
      if (dec.pair_hit[i]) sw_d[IDX_TEXT + i] = addr_lsb;
    end
    if (dec.ann_hit) sw_d[IDX_ANN3] = ~addr_lsb;
    for (int i = 0; i < N_WO; i++) begin
      if (dec.wo_hit[i]) sw_d[IDX_STORE80 + i] = addr_lsb;
    end
    // new key wins over a clear in the same cycle
    kstb_d = key_new ? 1'b1 : 1'b0;
    test_d = addr_lsb;
    spk_d  = ~spk_q;
    mask_d = wdata;
  end

  assign sw_en   = (|dec.pair_hit) || dec.ann_hit || (|dec.wo_hit);
  assign kstb_en = key_new || dec.kclr_hit;
  assign test_en = dec.test_hit;
  assign spk_en  = dec.spk_hit;
  assign mask_en = dec.mask_wr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      kstb_q <= 1'b0;
      test_q <= 1'b0;
      spk_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (sw_en)   sw_q   <= sw_d;
      if (kstb_en) kstb_q <= kstb_d;
      if (test_en) test_q <= test_d;
      if (spk_en)  spk_q  <= spk_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign st.sw      = sw_q;
  assign st.kstrobe = kstb_q;
  assign st.test    = test_q;
  assign st.spkr    = spk_q;
  assign st.mask    = mask_q;

endmodule

// File: rtl/ioss_slot_route.sv
module ioss_slot_route #(
  parameter int         SLOT_CNT   = 8,
  parameter logic [7:0] SLOT_ALLOW = 8'hF6,
  localparam int        SLOT_W     = $clog2(SLOT_CNT)
) (
  input  logic              win_hit,
  input  logic              hi_win,
  input  logic [SLOT_W-1:0] slot_hi,
  input  logic [SLOT_W-1:0] slot_lo,
  input  logic [7:0]        mask,
  output logic [SLOT_W-1:0] slot,
  output logic              card_sel,
  output logic              irom_sel
);

  logic [SLOT_CNT-1:0] permitted;
  logic                slot_on;

  genvar s;
  generate
    for (s = 0; s < SLOT_CNT; s++) begin : g_perm
      assign permitted[s] = mask[s] & SLOT_ALLOW[s];
    end
  endgenerate

  always_comb begin
    slot = '0;
    if (win_hit) slot = hi_win ? slot_hi : slot_lo;
  end

  assign slot_on  = permitted[slot];
  assign card_sel = win_hit && slot_on;
  assign irom_sel = win_hit && !slot_on;

endmodule

// File: rtl/ioss_read_mux.sv
module ioss_read_mux
  import ioss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dec_t              dec,
  input  state_t            st,
  input  logic              wr,
  input  logic              key_down,
  input  logic              card_sel,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] BIT7   = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] NOCARD = {DATA_W{1'b1}};

  logic [7:0] stat_vec;

  // status order as seen by C018..C01F
  assign stat_vec = {st.sw[IDX_COL80], st.sw[IDX_ALTCH], st.sw[IDX_HIRES],
                     st.sw[IDX_PAGE2], st.sw[IDX_MIXED], st.sw[IDX_TEXT],
                     1'b0, st.sw[IDX_STORE80]};

  always_comb begin
    rd_data = '0;
    if (card_sel && !wr)   rd_data = NOCARD;
    else if (dec.stat_rd)  rd_data = stat_vec[dec.stat_sel] ? BIT7 : '0;
    else if (dec.ann_rd)   rd_data = st.sw[IDX_ANN3] ? BIT7 : '0;
    else if (dec.kbd_rd)   rd_data = st.kstrobe ? BIT7 : '0;
    else if (dec.kdown_rd) rd_data = key_down ? BIT7 : '0;
    else if (dec.test_rd)  rd_data = st.test ? BIT7 : '0;
    else if (dec.mask_rd)  rd_data = DATA_W'(st.mask);
  end

endmodule

// File: rtl/io_softswitch_decoder.sv
module io_softswitch_decoder
  import ioss_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         SLOT_CNT   = 8,
  parameter logic [7:0] SLOT_ALLOW = 8'hF6,
  localparam int        SLOT_W     = $clog2(SLOT_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              key_down,
  input  logic              key_new,
  output logic [DATA_W-1:0] rd_data,
  output logic [SW_W-1:0]   disp_sw,
  output logic              test_mode,
  output logic              spkr_out,
  output logic [SLOT_W-1:0] slot_num,
  output logic              card_sel,
  output logic              irom_sel
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  dec_t       dec;
  state_t     st;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ioss_decode u_dec (
    .req  (bus_req),
    .wr   (bus_wr),
    .addr (bus_addr),
    .dec  (dec)
  );

  ioss_switch_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .dec      (dec),
    .addr_lsb (bus_addr[0]),
    .wdata    (bus_wdata),
    .key_new  (key_new),
    .st       (st)
  );

  ioss_slot_route #(
    .SLOT_CNT   (SLOT_CNT),
    .SLOT_ALLOW (SLOT_ALLOW)
  ) u_route (
    .win_hit  (dec.win_hit),
    .hi_win   (dec.hi_win),
    .slot_hi  (bus_addr[8 +: SLOT_W]),
    .slot_lo  (bus_addr[4 +: SLOT_W]),
    .mask     (st.mask),
    .slot     (slot_num),
    .card_sel (card_sel),
    .irom_sel (irom_sel)
  );

  ioss_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .dec      (dec),
    .st       (st),
    .wr       (bus_wr),
    .key_down (key_down),
    .card_sel (card_sel),
    .rd_data  (rd_data)
  );

  assign disp_sw   = st.sw;
  assign test_mode = st.test;
  assign spkr_out  = st.spkr;

endmodule

// File: rtl/ioss_checker.sv
module ioss_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic [15:0] bus_addr,
  input logic [7:0]  rd_data,
  input logic [7:0]  disp_sw,
  input logic        test_mode,
  input logic        spkr_out,
  input logic        card_sel,
  input logic        irom_sel
);

  assert_page2_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC054) |=> !disp_sw[2]);

  assert_hires_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC057) |=> disp_sw[3]);

  assert_ann3_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC05E) |=> disp_sw[4]);

  assert_ann3_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC05F) |=> !disp_sw[4]);

  assert_col80_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_addr[15:1] == 15'h6006) |=> $stable(disp_sw[6]));

  assert_test_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC06F) |=> test_mode);

  assert_spk_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == 16'hC030) |=> (spkr_out != $past(spkr_out)));

  assert_card_float_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (card_sel && !bus_wr) |-> (rd_data == 8'hFF));

  assert_sel_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_sel && irom_sel));

  assert_sel_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (card_sel || irom_sel) |-> bus_req);

endmodule

bind io_softswitch_decoder ioss_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .rd_data   (rd_data),
  .disp_sw   (disp_sw),
  .test_mode (test_mode),
  .spkr_out  (spkr_out),
  .card_sel  (card_sel),
  .irom_sel  (irom_sel)
);

// File: tb/io_softswitch_decoder_test.sv
module io_softswitch_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        bus_req, bus_wr, key_down, key_new;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  rd_data, disp_sw;
  logic        test_mode, spkr_out, card_sel, irom_sel;
  logic [2:0]  slot_num;

  int checks = 0;
  int fails  = 0;
  logic [7:0] s_rd;
  logic       s_card, s_irom;
  logic [2:0] s_slot;

  io_softswitch_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .key_down(key_down),
    .key_new(key_new), .rd_data(rd_data), .disp_sw(disp_sw),
    .test_mode(test_mode), .spkr_out(spkr_out), .slot_num(slot_num),
    .card_sel(card_sel), .irom_sel(irom_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {wr, addr, wdata, expected read, expected disp_sw after the edge}
  localparam int NV = 23;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {1'b0, 16'hC051, 8'h00, 8'h00, 8'h01},  // R2 text on by read
    {1'b1, 16'hC053, 8'h5A, 8'h00, 8'h03},  // R2 mixed on by write
    {1'b0, 16'hC055, 8'h00, 8'h00, 8'h07},  // R2 page2
    {1'b1, 16'hC057, 8'h00, 8'h00, 8'h0F},  // R2 hires
    {1'b0, 16'hC01A, 8'h00, 8'h80, 8'h0F},  // R5 text status
    {1'b0, 16'hC01D, 8'h00, 8'h80, 8'h0F},  // R5 hires status
    {1'b0, 16'hC05E, 8'h00, 8'h00, 8'h1F},  // R3 ann3 on
    {1'b0, 16'hC046, 8'h00, 8'h80, 8'h1F},  // R5 ann3 status
    {1'b1, 16'hC05F, 8'hFF, 8'h00, 8'h0F},  // R3 ann3 off
    {1'b0, 16'hC001, 8'h00, 8'h00, 8'h0F},  // R4 read leaves 80-store
    {1'b1, 16'hC001, 8'h00, 8'h00, 8'h2F},  // R4 80-store on
    {1'b1, 16'hC00D, 8'h00, 8'h00, 8'h6F},  // R4 80-column on
    {1'b1, 16'hC00F, 8'h00, 8'h00, 8'hEF},  // R4 alt charset on
    {1'b0, 16'hC018, 8'h00, 8'h80, 8'hEF},  // R5 80-store status
    {1'b0, 16'hC01F, 8'h00, 8'h80, 8'hEF},  // R5 80-column status
    {1'b0, 16'hC01E, 8'h00, 8'h80, 8'hEF},  // R5 alt charset status
    {1'b1, 16'hC00C, 8'h00, 8'h00, 8'hAF},  // R4 80-column off
    {1'b0, 16'hC01F, 8'h00, 8'h00, 8'hAF},  // R5 80-column status now 0
    {1'b0, 16'hC019, 8'h00, 8'h00, 8'hAF},  // R5 C019 always 0
    {1'b0, 16'hC050, 8'h00, 8'h00, 8'hAE},  // R2 text off
    {1'b0, 16'hC01A, 8'h00, 8'h00, 8'hAE},  // R5 text status 0
    {1'b1, 16'hC052, 8'h00, 8'h00, 8'hAC},  // R2 mixed off
    {1'b0, 16'hC01B, 8'h00, 8'h00, 8'hAC}   // R5 mixed status 0
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #2;
    s_rd = rd_data; s_card = card_sel; s_irom = irom_sel; s_slot = slot_num;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wr = 1'b0; key_new = 1'b0;
  endtask

  task automatic pulse_key();
    @(negedge clk); key_new = 1'b1;
    @(posedge clk); #1; key_new = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = 16'h0;
    bus_wdata = 8'h0; key_down = 1'b0; key_new = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    check("R1 disp_sw", disp_sw, 8'h00);
    check("R1 test/spk", {6'b0, test_mode, spkr_out}, 8'h00);
    acc(1'b0, 16'hC02D, 8'h00);
    check("R1 card mask", s_rd, 8'h00);
    acc(1'b0, 16'hC000, 8'h00);
    check("R1 strobe", s_rd, 8'h00);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][40], VEC[i][39:24], VEC[i][23:16]);
      check($sformatf("R2-5 vec%0d rd", i), s_rd, VEC[i][15:8]);
      check($sformatf("R2-5 vec%0d sw", i), disp_sw, VEC[i][7:0]);
    end

    // R6 strobe set by new key, seen at C000
    pulse_key();
    acc(1'b0, 16'hC000, 8'h00);
    check("R6 strobe set", s_rd, 8'h80);
    // R7 read C010 returns key_down and clears
    key_down = 1'b1;
    acc(1'b0, 16'hC010, 8'h00);
    check("R7 key_down read", s_rd, 8'h80);
    acc(1'b0, 16'hC000, 8'h00);
    check("R7 strobe cleared by read", s_rd, 8'h00);
    key_down = 1'b0;
    acc(1'b0, 16'hC010, 8'h00);
    check("R7 key_down low", s_rd, 8'h00);
    // R7 write clear
    pulse_key();
    acc(1'b1, 16'hC010, 8'h00);
    acc(1'b0, 16'hC000, 8'h00);
    check("R7 strobe cleared by write", s_rd, 8'h00);
    // R6 collision: new key wins
    @(negedge clk); key_new = 1'b1;
    acc(1'b0, 16'hC010, 8'h00);
    acc(1'b0, 16'hC000, 8'h00);
    check("R6 new key beats clear", s_rd, 8'h80);

    // R8 test mode
    acc(1'b0, 16'hC06F, 8'h00);
    check("R8 test set", {7'b0, test_mode}, 8'h01);
    acc(1'b0, 16'hC06D, 8'h00);
    check("R8 test read", s_rd, 8'h80);
    acc(1'b1, 16'hC06E, 8'h00);
    check("R8 test clear", {7'b0, test_mode}, 8'h00);
    acc(1'b0, 16'hC06D, 8'h00);
    check("R8 test read 0", s_rd, 8'h00);

    // R9 speaker
    acc(1'b0, 16'hC030, 8'h00);
    check("R9 toggle on read", {7'b0, spkr_out}, 8'h01);
    acc(1'b1, 16'hC030, 8'h00);
    check("R9 toggle on write", {7'b0, spkr_out}, 8'h00);

    // R10 card mask
    acc(1'b1, 16'hC02D, 8'hFF);
    acc(1'b0, 16'hC02D, 8'h00);
    check("R10 mask readback", s_rd, 8'hFF);

    // R11 R12 with mask FF
    acc(1'b0, 16'hC600, 8'h00);
    check("R11 slot hi C600", {5'b0, s_slot}, 8'h06);
    check("R12 card C600", {s_rd[7:2], s_card, s_irom}, 8'hFE);
    acc(1'b0, 16'hC0E4, 8'h00);
    check("R11 slot lo C0E4", {5'b0, s_slot}, 8'h06);
    check("R12 card C0E4", {6'b0, s_card, s_irom}, 8'h02);
    acc(1'b0, 16'hC300, 8'h00);
    check("R11 slot C300", {5'b0, s_slot}, 8'h03);
    check("R12 slot3 forced internal", {6'b0, s_card, s_irom}, 8'h01);
    acc(1'b0, 16'hC085, 8'h00);
    check("R11 slot C085", {5'b0, s_slot}, 8'h00);
    check("R12 slot0 forced internal", {6'b0, s_card, s_irom}, 8'h01);
    acc(1'b0, 16'hC100, 8'h00);
    check("R12 slot1 card", {6'b0, s_card, s_irom}, 8'h02);
    acc(1'b0, 16'hC050, 8'h00);
    check("R12 outside window", {3'b0, s_slot, s_card, s_irom}, 8'h00);
    // mask single bit
    acc(1'b1, 16'hC02D, 8'h10);
    acc(1'b0, 16'hC400, 8'h00);
    check("R12 mask 10 slot4 card", {6'b0, s_card, s_irom}, 8'h02);
    acc(1'b0, 16'hC500, 8'h00);
    check("R12 mask 10 slot5 rom", {6'b0, s_card, s_irom}, 8'h01);
    acc(1'b1, 16'hC02D, 8'h00);
    acc(1'b0, 16'hC0F0, 8'h00);
    check("R11 slot C0F0", {5'b0, s_slot}, 8'h07);
    check("R12 mask 0 rom", {s_rd[7:2], s_card, s_irom}, 8'h01);

    // R1 reset mid-run
    acc(1'b0, 16'hC051, 8'h00);
    acc(1'b0, 16'hC030, 8'h00);
    acc(1'b1, 16'hC02D, 8'hA5);
    @(negedge clk); rst_n = 1'b0; #2;
    check("R1 async clear sw", disp_sw, 8'h00);
    check("R1 async clear spk", {7'b0, spkr_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    acc(1'b0, 16'hC02D, 8'h00);
    check("R1 mask after reset", s_rd, 8'h00);

    finish_run();
  end

endmodule